// File: doc/BRIEF.md
# Timer Capture Unit with Filtered Trigger Inputs

This block holds a free-running up-counter and a set of channel registers, two by default. A trigger pin belongs to each channel. The pin is sampled on a sampling-enable strobe and passes through a two-sample agreement filter. An edge detector follows the filter, and the edge it detects can be chosen per channel.

When a channel is in capture mode, an accepted edge makes the channel latch the counter on the falling phase of the count clock. The channel then pulses its interrupt on the following rising phase. When a channel is in compare mode, the channel ignores its trigger. Its interrupt then pulses when the counter steps onto the stored value.

The count clock reaches the block as two single-cycle strobes on the system clock, one for the rising phase and one for the falling phase. A run input starts and stops the timer. Software reads the counter or a channel register through a registered read port. Software writes a channel register, which is how a compare value is loaded.

The pin filter has a defined start-up behaviour. On the first enable after reset, a pin already held high counts as a rising edge. On a later re-enable, a high pin produces no edge.

Top module: `cap_timer`

## Requirements
- R1: While `run` is high, `count` increases by one in the cycle after each `cnt_rise` strobe and holds otherwise; while `run` is low, `count` is zero.
- R2: A `cnt_rise` strobe with `count` at all ones wraps `count` to zero and sets `ovf`; `ovf` clears at the next `cnt_rise` strobe.
- R3: A new trigger level is accepted only after two successive `smp_en` samples both see it; a level present for one sample only is rejected and causes no capture and no interrupt.
- R4: Each channel has a 2-bit edge select, channel i using `edge_sel[2i+1:2i]`: 00 selects falling edges, 01 rising edges, 10 no edge, 11 both edges.
- R5: In capture mode (`cmp_mode[i]` low), an accepted edge makes the channel load the value of `count` into its register at the next `cnt_fall` strobe.
- R6: After a capture, `irq[i]` stays low on the `cnt_fall` strobe and is high for exactly one cycle, the cycle after the next `cnt_rise` strobe.
- R7: In compare mode (`cmp_mode[i]` high), a trigger never changes the channel register. `irq[i]` pulses for one cycle when a `cnt_rise` strobe brings `count` to the register value.
- R8: A read with `rd_sel` 0 returns `count` on `rd_data` the cycle after `rd_en`, and it changes no channel register. `rd_sel` i+1 returns the register of channel i.
- R9: While `run` is low, trigger activity produces no capture and no interrupt, even after `run` returns high.
- R10: On the first enable after reset, a pin held high counts as a rising edge once it has passed the filter. On an enable after a stop, a pin that is high produces no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Timer run (1) or stop (0) |
| cnt_rise | input | 1 | Count-clock rising-phase strobe |
| cnt_fall | input | 1 | Count-clock falling-phase strobe |
| smp_en | input | 1 | Trigger sampling strobe |
| trig | input | NCH | Trigger pins, one per channel |
| edge_sel | input | 2*NCH | Edge select, 2 bits per channel |
| cmp_mode | input | NCH | 1 selects compare mode for the channel |
| wr_en | input | 1 | Channel register write strobe |
| wr_sel | input | SW | Channel index for the write |
| wr_data | input | CW | Write data |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | RSW | 0 counter, i+1 channel i |
| rd_data | output | CW | Registered read data |
| count | output | CW | Counter value |
| ovf | output | 1 | Overflow flag |
| irq | output | NCH | Per-channel interrupt pulse |

## Verification
Four kinds of stimulus are applied to the trigger pins.

- A level held for two samples must be accepted, and a level held for one sample must be dropped. This pair separates the agreement filter from a plain synchronizer.
- Falling, rising, both and the reserved edge code are each driven. These runs show that the edge select is decoded per code and not per bit.
- A pin held high is tested across the first enable and across a later stop and restart. This run distinguishes power-up edge detection from re-enable edge detection.
- A trigger is applied to a channel in compare mode, and the counter is read. These runs show that neither action touches the register. The compare run also shows that the interrupt lands only on the step onto the stored value.

The counter is finally run through its wrap so that the overflow window can be seen.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_NONE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/cap_filter.sv
// Two-sample agreement filter followed by a programmable edge detector.
module cap_filter
  import cap_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      run,
  input  logic      smp_en,
  input  logic      pin,
  input  edge_sel_e sel,
  output logic      hit
);
  logic smp_q;     // last raw sample
  logic lvl_q;     // accepted level
  logic lvl_d1;    // accepted level, one cycle late
  logic ran_q;     // timer has run since reset

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q  <= 1'b0;
      lvl_q  <= 1'b0;
      lvl_d1 <= 1'b0;
      ran_q  <= 1'b0;
    end else begin
      if (run) ran_q <= 1'b1;
      lvl_d1 <= lvl_q;
      if (smp_en) begin
        if (run) begin
          smp_q <= pin;
          if (pin == smp_q) lvl_q <= pin;
        end else if (ran_q) begin
          // stopped after a run: follow the pin silently
          smp_q  <= pin;
          lvl_q  <= pin;
          lvl_d1 <= pin;
        end
      end
    end
  end

  logic rise, fall;
  assign rise = lvl_q & ~lvl_d1;
  assign fall = ~lvl_q & lvl_d1;

  always_comb begin
    unique case (sel)
      EDGE_FALL: hit = run & fall;
      EDGE_RISE: hit = run & rise;
      EDGE_BOTH: hit = run & (rise | fall);
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          cnt_rise,
  output logic [CW-1:0] count,
  output logic          ovf
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (cnt_rise) begin
      count <= count + CW'(1);
      ovf   <= (count == TOP);
    end
  end
endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          cnt_rise,
  input  logic          cnt_fall,
  input  logic          hit,
  input  logic          cmp_mode,
  input  logic [CW-1:0] count,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] reg_q,
  output logic          irq
);
  logic pend_q, arm_q, cap_now, cmp_hit;

  assign cap_now = run & ~cmp_mode & cnt_fall & (pend_q | hit);
  assign cmp_hit = run & cmp_mode & cnt_rise & ((count + CW'(1)) == reg_q);

  always_ff @(posedge clk) begin
    if (rst) reg_q <= '0;
    else if (cap_now) reg_q <= count;
    else if (wr_en) reg_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pend_q <= 1'b0;
      arm_q  <= 1'b0;
      irq    <= 1'b0;
    end else if (cmp_mode) begin
      pend_q <= 1'b0;
      arm_q  <= 1'b0;
      irq    <= cmp_hit;
    end else begin
      pend_q <= cap_now ? 1'b0 : (pend_q | hit);
      arm_q  <= cap_now | (arm_q & ~cnt_rise);
      irq    <= cnt_rise & arm_q;
    end
  end
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 2,
  localparam int SW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RSW = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             cnt_rise,
  input  logic             cnt_fall,
  input  logic             smp_en,
  input  logic [NCH-1:0]   trig,
  input  logic [2*NCH-1:0] edge_sel,
  input  logic [NCH-1:0]   cmp_mode,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_sel,
  input  logic [CW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [RSW-1:0]   rd_sel,
  output logic [CW-1:0]    rd_data,
  output logic [CW-1:0]    count,
  output logic             ovf,
  output logic [NCH-1:0]   irq
);
  logic [CW-1:0] regs [NCH];
  logic [NCH-1:0] hit;

  cap_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .cnt_rise(cnt_rise),
    .count(count), .ovf(ovf)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cap_filter u_flt (
      .clk(clk), .rst(rst), .run(run), .smp_en(smp_en), .pin(trig[i]),
      .sel(edge_sel_e'(edge_sel[2*i +: 2])), .hit(hit[i])
    );
    cap_channel #(.CW(CW)) u_chn (
      .clk(clk), .rst(rst), .run(run), .cnt_rise(cnt_rise),
      .cnt_fall(cnt_fall), .hit(hit[i]), .cmp_mode(cmp_mode[i]),
      .count(count), .wr_en(wr_en && (wr_sel == SW'(i))),
      .wr_data(wr_data), .reg_q(regs[i]), .irq(irq[i])
    );
  end

  logic [CW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (rd_sel == '0) rd_next = count;
    for (int i = 0; i < NCH; i++)
      if (rd_sel == RSW'(i + 1)) rd_next = regs[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int CW  = 16,
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           run,
  input logic           cnt_rise,
  input logic [CW-1:0]  count,
  input logic           ovf,
  input logic [NCH-1:0] irq
);
  // R1
  stop_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (count == '0));
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_rise) |=> (count == CW'($past(count) + CW'(1))));
  // R1
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !cnt_rise && $past(run)) |=> $stable(count));
  // R2
  wrap_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_rise && count == {CW{1'b1}}) |=> (ovf && count == '0));
  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    (irq != '0) |=> ((irq & $past(irq)) == '0));
  // R6
  irq_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (irq != '0) |-> $past(cnt_rise));
  // R9
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (irq == '0));
endmodule

bind cap_timer cap_timer_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .run(run), .cnt_rise(cnt_rise),
  .count(count), .ovf(ovf), .irq(irq)
);

// File: tb/cap_timer_tb.sv
module cap_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0, cnt_rise = 1'b0, cnt_fall = 1'b0, smp_en = 1'b0;
  logic [NCH-1:0] trig = '0;
  logic [2*NCH-1:0] edge_sel = 4'b0101;
  logic [NCH-1:0] cmp_mode = '0;
  logic wr_en = 1'b0;
  logic [0:0] wr_sel = '0;
  logic [CW-1:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [1:0] rd_sel = '0;
  logic [CW-1:0] rd_data, count;
  logic ovf;
  logic [NCH-1:0] irq;

  int total = 0, failed = 0;
  int exp_cnt = 0;
  logic [CW-1:0] saved;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_timer #(.CW(CW), .NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .run(run), .cnt_rise(cnt_rise), .cnt_fall(cnt_fall),
    .smp_en(smp_en), .trig(trig), .edge_sel(edge_sel), .cmp_mode(cmp_mode),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_data(rd_data), .count(count), .ovf(ovf), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe_rise();
    @(negedge clk) cnt_rise = 1'b1;
    @(negedge clk) cnt_rise = 1'b0;
    if (run) exp_cnt = (exp_cnt + 1) & 32'hFFFF;
  endtask
  task automatic strobe_fall();
    @(negedge clk) cnt_fall = 1'b1;
    @(negedge clk) cnt_fall = 1'b0;
  endtask
  task automatic sample();
    @(negedge clk) smp_en = 1'b1;
    @(negedge clk) smp_en = 1'b0;
  endtask
  task automatic set_run(input logic v);
    @(negedge clk) run = v;
    if (!v) exp_cnt = 0;
    @(negedge clk);
  endtask
  task automatic read_reg(input logic [1:0] sel, output logic [CW-1:0] val);
    @(negedge clk) begin rd_en = 1'b1; rd_sel = sel; end
    @(negedge clk) rd_en = 1'b0;
    val = rd_data;
  endtask
  task automatic write_reg(input logic [0:0] sel, input logic [CW-1:0] val);
    @(negedge clk) begin wr_en = 1'b1; wr_sel = sel; wr_data = val; end
    @(negedge clk) wr_en = 1'b0;
  endtask
  // fall then rise; checks irq0 stays low at fall and equals exp at rise
  task automatic fire_ch0(input string req, input logic exp_irq);
    strobe_fall();
    check({req, " irq0 at fall"}, irq[0], 0);
    strobe_rise();
    check({req, " irq0 after rise"}, irq[0], exp_irq);
    @(negedge clk);
    check({req, " irq0 single cycle"}, irq[0], 0);
  endtask

  task automatic t_reset();
    logic [CW-1:0] v;
    check("R1 reset count", count, 0);
    check("R2 reset ovf", ovf, 0);
    check("R6 reset irq", irq, 0);
    read_reg(2'd1, v);
    check("R8 reset reg0", v, 0);
  endtask

  task automatic t_powerup();
    logic [CW-1:0] v;
    trig[0] = 1'b1;
    set_run(1'b1);
    sample(); sample();
    strobe_rise(); strobe_rise(); strobe_rise();
    check("R1 count after three strobes", count, exp_cnt);
    saved = count;
    fire_ch0("R10 power-up edge", 1'b1);
    read_reg(2'd1, v);
    check("R5 R10 captured value", v, saved);
  endtask

  task automatic t_reenable();
    logic [CW-1:0] v;
    set_run(1'b0);
    check("R1 count zero when stopped", count, 0);
    sample();
    set_run(1'b1);
    sample(); sample();
    strobe_rise();
    fire_ch0("R10 re-enable no edge", 1'b0);
    read_reg(2'd1, v);
    check("R10 reg0 kept", v, saved);
  endtask

  task automatic t_stopped();
    logic [CW-1:0] v;
    set_run(1'b0);
    trig[0] = 1'b0; sample(); sample();
    trig[0] = 1'b1; sample(); sample();
    strobe_fall(); strobe_rise();
    check("R9 no irq while stopped", irq, 0);
    set_run(1'b1);
    strobe_rise();
    fire_ch0("R9 after restart", 1'b0);
    read_reg(2'd1, v);
    check("R9 reg0 kept", v, saved);
  endtask

  task automatic t_filter();
    logic [CW-1:0] v;
    trig[0] = 1'b0; sample(); sample();
    trig[0] = 1'b1; sample();
    trig[0] = 1'b0; sample(); sample();
    fire_ch0("R3 short pulse rejected", 1'b0);
    read_reg(2'd1, v);
    check("R3 reg0 unchanged by glitch", v, saved);
    trig[0] = 1'b1; sample(); sample();
    strobe_rise(); strobe_rise();
    saved = CW'(exp_cnt);
    fire_ch0("R3 two-sample level accepted", 1'b1);
    read_reg(2'd1, v);
    check("R3 R5 capture after filter", v, saved);
  endtask

  task automatic t_edges();
    logic [CW-1:0] v;
    edge_sel[1:0] = 2'b00;
    trig[0] = 1'b0; sample(); sample(); strobe_rise();
    saved = CW'(exp_cnt);
    fire_ch0("R4 falling select", 1'b1);
    read_reg(2'd1, v);
    check("R4 falling capture", v, saved);
    edge_sel[1:0] = 2'b11;
    trig[0] = 1'b1; sample(); sample(); strobe_rise(); strobe_rise();
    saved = CW'(exp_cnt);
    fire_ch0("R4 both select rising", 1'b1);
    read_reg(2'd1, v);
    check("R4 both capture", v, saved);
    edge_sel[1:0] = 2'b10;
    trig[0] = 1'b0; sample(); sample(); strobe_rise();
    fire_ch0("R4 reserved select", 1'b0);
    read_reg(2'd1, v);
    check("R4 reserved no capture", v, saved);
    edge_sel[1:0] = 2'b01;
  endtask

  task automatic t_compare();
    logic [CW-1:0] v, tgt;
    cmp_mode[1] = 1'b1;
    tgt = CW'(exp_cnt + 5);
    write_reg(1'b1, tgt);
    trig[1] = 1'b1; sample(); sample();
    strobe_fall();
    read_reg(2'd2, v);
    check("R7 compare reg not captured", v, tgt);
    for (int k = 0; k < 7; k++) begin
      strobe_rise();
      check("R7 compare irq1", irq[1], (exp_cnt == int'(tgt)) ? 1 : 0);
    end
  endtask

  task automatic t_bus_read();
    logic [CW-1:0] v0, v1, c;
    read_reg(2'd1, v0);
    read_reg(2'd0, c);
    check("R8 counter read", c, exp_cnt);
    read_reg(2'd1, v1);
    check("R8 read leaves reg0", v1, v0);
  endtask

  task automatic t_overflow();
    int n;
    n = 16'hFFFF - exp_cnt;
    @(negedge clk) cnt_rise = 1'b1;
    repeat (n) @(negedge clk);
    cnt_rise = 1'b0;
    exp_cnt = 16'hFFFF;
    check("R2 count at top", count, 32'hFFFF);
    check("R2 no ovf before wrap", ovf, 0);
    strobe_rise();
    check("R2 wrapped count", count, 0);
    check("R2 ovf set", ovf, 1);
    strobe_rise();
    check("R2 ovf cleared", ovf, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_powerup();
    t_reenable();
    t_stopped();
    t_filter();
    t_edges();
    t_compare();
    t_bus_read();
    t_overflow();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule